// File: doc/BRIEF.md
# Regular Conversion Sequencer

This controller walks a programmable list of channel ranks and drives an abstract converter one channel at a time. For each step it presents a channel number with a one-cycle start pulse. It then waits for the converter to report the end of sampling and the end of conversion with a data word. The newest result is kept in a data register, which has a read port.

Software programs the block through a small word-addressed write port. Addresses `0..RANKS-1` each hold one rank's channel number. One address holds the mode word, one holds the run/stop command bits, and one takes write-one-to-clear masks for the four status flags. The controller has three run modes: single pass, continuous, and discontinuous (a short burst of ranks per trigger). It can be triggered by software as soon as the run bit is set, or by rising edges on one trigger input.

Top module: `regseq_ctrl`

## Requirements
- R1: After reset, `run`, `stopping`, `conv_start`, `conv_abort`, all four flags and `dr_data` are 0.
- R2: A write to address i (0..15) stores wdata[4:0] as the channel of rank i. Mode wdata[3:0] holds the rank count minus one. One pass launches ranks 0 up to that count, in rank order, and shows each rank's channel on `conv_chan` alongside a one-cycle `conv_start`.
- R3: In single mode (mode bits 20 and 21 clear), the behaviour depends on the trigger source. With the software trigger (mode bit 23 clear), `run` falls on the same edge that sets the end-of-sequence flag. With the edge trigger (bit 23 set), each rising edge of `trig` runs one full pass, and `run` stays set.
- R4: In continuous mode (mode bit 20), rank 0 is relaunched straight after the last rank, and every pass sets end-of-sequence. This repeats until a stop command.
- R5: In discontinuous mode (mode bit 21), each trigger converts a burst of wdata[18:16]+1 ranks. The next burst resumes at the following rank. A burst is cut short at the last rank, which sets end-of-sequence and wraps to rank 0.
- R6: In discontinuous mode with the software trigger, `run` falls on the end-of-conversion that closes each burst.
- R7: A mode write that sets both bit 20 and bit 21 is dropped whole, and the previous mode stays in force.
- R8: The end-of-conversion flag sets whenever new data is accepted. A clear-mask write with bit 1 set clears it. A one-cycle `dr_rd` pulse also clears it. A new set in the same cycle wins over a clear.
- R9: An overrun sets when a conversion completes while the end-of-conversion flag is still set. With mode bit 22 clear, the data register keeps its old value on overrun. With bit 22 set, the data register takes the new result.
- R10: Control write bit 1, sent while `run` is high, raises `stopping` and `conv_abort` for one cycle. On the next edge, `run` and `stopping` both clear and the rank pointer returns to rank 0. Converter reports that arrive after that are ignored.
- R11: The end-of-sampling flag sets when `conv_smp_done` arrives for the channel in progress.
- R12: While `run` is high, writes to rank addresses and to the mode word are ignored.
- R13: Writes to address 18 clear flags bit by bit: bit 0 end-of-sampling, bit 1 end-of-conversion, bit 2 end-of-sequence, bit 3 overrun. Flags whose mask bit is 0 are not affected. Control write bit 0 sets `run` only while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | AW (5) | Word address: ranks, mode (16), control (17), flag clear (18) |
| cfg_wdata | input | 32 | Write data |
| trig | input | 1 | Trigger, rising edge used when edge triggering is selected |
| dr_rd | input | 1 | Data register read pulse |
| dr_data | output | DW (16) | Data register |
| conv_start | output | 1 | One-cycle launch of a conversion |
| conv_chan | output | CHW (5) | Channel of the launched conversion |
| conv_abort | output | 1 | Discard the ongoing conversion |
| conv_smp_done | input | 1 | Sampling phase finished |
| conv_done | input | 1 | Conversion finished, data valid |
| conv_data | input | DW (16) | Conversion result |
| run | output | 1 | Run (start) bit |
| stopping | output | 1 | Stop command pending |
| flag_eosmp | output | 1 | End-of-sampling flag |
| flag_eoc | output | 1 | End-of-conversion flag |
| flag_eos | output | 1 | End-of-sequence flag |
| flag_ovr | output | 1 | Overrun flag |

## Verification
The bench builds the block at its defaults: 16 ranks, 5-bit channels, 16-bit data and a 3-bit burst field. At these values the full-length sequence is reachable, as are channel numbers up to 31 and bursts of up to eight ranks. A behavioural converter with a stall control returns results tagged with channel and serial number. This makes rank order, wrap-around, the choice between kept and overwritten data, and the discarding of a stalled conversion all visible at the ports.

// File: rtl/regseq_ctrl.sv
module regseq_ctrl #(
  parameter int RANKS = 16,
  parameter int CHW   = 5,
  parameter int DW    = 16,
  parameter int BW    = 3,
  localparam int LENW = $clog2(RANKS),
  localparam int AW   = $clog2(RANKS + 3)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [AW-1:0]  cfg_addr,
  input  logic [31:0]    cfg_wdata,
  input  logic           trig,
  input  logic           dr_rd,
  output logic [DW-1:0]  dr_data,
  output logic           conv_start,
  output logic [CHW-1:0] conv_chan,
  output logic           conv_abort,
  input  logic           conv_smp_done,
  input  logic           conv_done,
  input  logic [DW-1:0]  conv_data,
  output logic           run,
  output logic           stopping,
  output logic           flag_eosmp,
  output logic           flag_eoc,
  output logic           flag_eos,
  output logic           flag_ovr
);

  localparam logic [AW-1:0] A_MODE = AW'(RANKS);
  localparam logic [AW-1:0] A_CTRL = AW'(RANKS + 1);
  localparam logic [AW-1:0] A_CLR  = AW'(RANKS + 2);
  localparam int B_CONT = 20;
  localparam int B_DISC = 21;
  localparam int B_OVW  = 22;
  localparam int B_HW   = 23;

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_CONV} st_t;

  st_t            st, nst;
  logic           start_q, stop_q, nstart;
  logic [LENW-1:0] len_q, idx_q, nidx;
  logic [BW-1:0]  burst_q, bcnt_q, nb;
  logic           cont_q, disc_q, ovw_q, hw_q;
  logic [CHW-1:0] rank_q [RANKS];
  logic           trig_q, cs_q, launch;
  logic [CHW-1:0] ch_q;
  logic [DW-1:0]  dr_q;
  logic           f_smp, f_eoc, f_eos, f_ovr;

  wire wr_rank  = cfg_we && (cfg_addr < A_MODE) && !start_q;
  wire wr_mode  = cfg_we && (cfg_addr == A_MODE) && !start_q
                  && !(cfg_wdata[B_CONT] && cfg_wdata[B_DISC]);
  wire wr_ctrl  = cfg_we && (cfg_addr == A_CTRL);
  wire wr_clr   = cfg_we && (cfg_addr == A_CLR);
  wire go_start = wr_ctrl && cfg_wdata[0] && !start_q;
  wire go_stop  = wr_ctrl && cfg_wdata[1] && start_q && !stop_q;
  wire trig_edge = trig && !trig_q;
  wire done_ok  = (st == S_CONV) && conv_done && !stop_q;
  wire smp_ok   = (st == S_CONV) && conv_smp_done && !stop_q;
  wire last     = (idx_q == len_q);
  wire bend     = disc_q && (bcnt_q == burst_q);
  wire eos_set  = done_ok && last;
  wire ovr_hit  = done_ok && f_eoc;

  always_comb begin
    nst = st; nstart = start_q; nidx = idx_q; nb = bcnt_q; launch = 1'b0;
    case (st)
      S_ARM: if (!stop_q && (!hw_q || trig_edge)) begin
        launch = 1'b1; nst = S_CONV; nb = '0;
      end
      S_CONV: if (done_ok) begin
        if (last) begin
          nidx = '0; nb = '0;
          if (cont_q) launch = 1'b1;
          else if (hw_q) nst = S_ARM;
          else begin nst = S_IDLE; nstart = 1'b0; end
        end else begin
          nidx = idx_q + 1'b1;
          if (bend) begin
            nb = '0;
            if (hw_q) nst = S_ARM;
            else begin nst = S_IDLE; nstart = 1'b0; end
          end else begin
            launch = 1'b1; nb = bcnt_q + 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; start_q <= 1'b0; stop_q <= 1'b0;
      idx_q <= '0; bcnt_q <= '0; cs_q <= 1'b0; ch_q <= '0; trig_q <= 1'b0;
    end else begin
      trig_q <= trig;
      cs_q   <= 1'b0;
      if (stop_q) begin
        st <= S_IDLE; start_q <= 1'b0; stop_q <= 1'b0;
        idx_q <= '0; bcnt_q <= '0;
      end else if (go_start) begin
        start_q <= 1'b1; st <= S_ARM;
      end else begin
        if (go_stop) stop_q <= 1'b1;
        st      <= nst;
        start_q <= nstart | go_stop;
        idx_q   <= nidx;
        bcnt_q  <= nb;
        if (launch) begin
          cs_q <= 1'b1;
          ch_q <= rank_q[nidx];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0; burst_q <= '0; cont_q <= 1'b0; disc_q <= 1'b0;
      ovw_q <= 1'b0; hw_q <= 1'b0;
    end else if (wr_mode) begin
      len_q   <= cfg_wdata[LENW-1:0];
      burst_q <= cfg_wdata[16 +: BW];
      cont_q  <= cfg_wdata[B_CONT];
      disc_q  <= cfg_wdata[B_DISC];
      ovw_q   <= cfg_wdata[B_OVW];
      hw_q    <= cfg_wdata[B_HW];
    end
  end

  for (genvar i = 0; i < RANKS; i++) begin : g_rank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rank_q[i] <= '0;
      else if (wr_rank && cfg_addr == AW'(i)) rank_q[i] <= cfg_wdata[CHW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_smp <= 1'b0; f_eoc <= 1'b0; f_eos <= 1'b0; f_ovr <= 1'b0; dr_q <= '0;
    end else begin
      f_smp <= smp_ok  | (f_smp & ~(wr_clr & cfg_wdata[0]));
      f_eoc <= done_ok | (f_eoc & ~((wr_clr & cfg_wdata[1]) | dr_rd));
      f_eos <= eos_set | (f_eos & ~(wr_clr & cfg_wdata[2]));
      f_ovr <= ovr_hit | (f_ovr & ~(wr_clr & cfg_wdata[3]));
      if (done_ok && !(ovr_hit && !ovw_q)) dr_q <= conv_data;
    end
  end

  assign dr_data    = dr_q;
  assign conv_start = cs_q;
  assign conv_chan  = ch_q;
  assign conv_abort = stop_q;
  assign run        = start_q;
  assign stopping   = stop_q;
  assign flag_eosmp = f_smp;
  assign flag_eoc   = f_eoc;
  assign flag_eos   = f_eos;
  assign flag_ovr   = f_ovr;

  AST_STOP_SELF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |=> !stop_q && !start_q); // R10
  AST_STOP_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |-> start_q); // R10
  AST_LAUNCH_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> start_q); // R2
  AST_SW_SINGLE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    eos_set && !cont_q && !disc_q && !hw_q |=> !start_q); // R3
  AST_MODES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cont_q && disc_q)); // R7
  AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_hit && !ovw_q |=> $stable(dr_q)); // R9
  AST_READ_CLEARS_EOC: assert property (@(posedge clk) disable iff (!rst_n)
    dr_rd && !done_ok |=> !f_eoc); // R8
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    start_q && $past(start_q) |-> $stable(len_q) && $stable(cont_q) && $stable(disc_q)); // R12

endmodule

// File: tb/sim_regseq_ctrl.sv
module sim_regseq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_MODE = 5'd16, A_CTRL = 5'd17, A_CLR = 5'd18;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, trig = 1'b0, dr_rd = 1'b0;
  logic [4:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic conv_smp_done = 1'b0, conv_done = 1'b0;
  logic [15:0] conv_data = '0, dr_data;
  logic conv_start, conv_abort, run, stopping;
  logic [4:0] conv_chan;
  logic flag_eosmp, flag_eoc, flag_eos, flag_ovr;

  int checks = 0, fails = 0;

  regseq_ctrl u0 (.clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .trig, .dr_rd,
    .dr_data, .conv_start, .conv_chan, .conv_abort, .conv_smp_done, .conv_done,
    .conv_data, .run, .stopping, .flag_eosmp, .flag_eoc, .flag_eos, .flag_ovr);

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural converter
  logic [4:0]  chlog [0:255];
  logic [15:0] dlog  [0:255];
  int nlog = 0, cnt = 0;
  bit busy = 0, stall = 0;
  logic [4:0] cur_ch = '0;
  logic [7:0] serial = '0;

  always @(negedge clk) begin
    conv_smp_done <= 1'b0;
    conv_done <= 1'b0;
    if (!rst_n || conv_abort) busy <= 0;
    else if (conv_start) begin
      busy <= 1; cnt <= 3; cur_ch <= conv_chan;
      chlog[nlog[7:0]] <= conv_chan;
    end else if (busy && !stall) begin
      if (cnt == 2) conv_smp_done <= 1'b1;
      if (cnt == 1) begin
        conv_done <= 1'b1;
        conv_data <= {cur_ch, 3'b000, serial};
        dlog[nlog[7:0]] <= {cur_ch, 3'b000, serial};
        serial <= serial + 8'd1;
        nlog <= nlog + 1;
        busy <= 0;
      end
      cnt <= cnt - 1;
    end
  end

  function automatic logic [4:0] rchan(int i);
    return 5'((i * 7 + 3) % 32);
  endfunction

  function automatic logic [31:0] mk_mode(int len, int burst, bit cont, bit disc, bit ovw, bit hw);
    return 32'(len) | (32'(burst) << 16) | (32'(cont) << 20) | (32'(disc) << 21)
         | (32'(ovw) << 22) | (32'(hw) << 23);
  endfunction

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    tick(); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick(); cfg_we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400 && run; i++) tick();
  endtask

  task automatic wait_convs(int n);
    for (int i = 0; i < 400 && nlog < n; i++) tick();
    repeat (2) tick();
  endtask

  task automatic check_order(int base, int cnt0, int first_rank, int len, string tag);
    for (int k = 0; k < cnt0; k++) begin
      int r = (first_rank + k) % len;
      check(chlog[base + k] == rchan(r), tag, chlog[base + k], rchan(r));
    end
  endtask

  task automatic t_reset();
    check(!run && !stopping && !conv_start && !conv_abort, "R1 control", run, 0);
    check({flag_eosmp, flag_eoc, flag_eos, flag_ovr} == 4'b0, "R1 flags",
          {flag_eosmp, flag_eoc, flag_eos, flag_ovr}, 0);
    check(dr_data == 16'd0, "R1 data", dr_data, 0);
  endtask

  task automatic t_single_sw();
    int b = nlog;
    wr(A_MODE, mk_mode(3, 0, 0, 0, 1, 0));
    wr(A_CTRL, 32'h1);
    wait_idle();
    check(nlog - b == 4, "R2 count", nlog - b, 4);
    check_order(b, 4, 0, 16, "R2 order");
    check(!run && flag_eos, "R3 sw single run/eos", run, 0);
    check(flag_eosmp, "R11 eosmp", flag_eosmp, 1);
    check(flag_eoc && flag_ovr, "R9 ovr set", flag_ovr, 1);
    check(dr_data == dlog[nlog - 1], "R9 overwrite", dr_data, dlog[nlog - 1]);
    wr(A_CLR, 32'h2);
    check(!flag_eoc && flag_eos && flag_ovr && flag_eosmp, "R13 bitwise clear",
          {flag_eosmp, flag_eoc, flag_eos, flag_ovr}, 4'b1011);
    wr(A_CLR, 32'hF);
    check({flag_eosmp, flag_eoc, flag_eos, flag_ovr} == 4'b0, "R13 clear all",
          {flag_eosmp, flag_eoc, flag_eos, flag_ovr}, 0);
  endtask

  task automatic t_keep_and_read();
    int b = nlog;
    wr(A_MODE, mk_mode(2, 0, 0, 0, 0, 0));
    wr(A_CTRL, 32'h1);
    wait_idle();
    check(dr_data == dlog[b], "R9 keep old data", dr_data, dlog[b]);
    check(flag_ovr, "R9 ovr keep mode", flag_ovr, 1);
    tick(); dr_rd = 1'b1; tick(); dr_rd = 1'b0;
    check(!flag_eoc, "R8 read clears eoc", flag_eoc, 0);
    wr(A_CLR, 32'hF);
    wr(A_MODE, mk_mode(0, 0, 0, 0, 0, 0));
    wr(A_CTRL, 32'h1);
    wait_idle();
    check(flag_eoc && !flag_ovr, "R9 single rank no ovr", flag_ovr, 0);
    check(dr_data == dlog[nlog - 1], "R8 new data", dr_data, dlog[nlog - 1]);
    wr(A_CLR, 32'hF);
  endtask

  task automatic t_forbidden();
    int b = nlog;
    wr(A_MODE, mk_mode(3, 0, 1, 1, 0, 0));
    wr(A_CTRL, 32'h1);
    wait_idle();
    check(nlog - b == 1 && !run, "R7 mode write dropped", nlog - b, 1);
    wr(A_CLR, 32'hF);
  endtask

  task automatic t_disc_sw();
    int b = nlog;
    wr(A_MODE, mk_mode(4, 1, 0, 1, 1, 0));
    wr(A_CTRL, 32'h1); wait_idle();
    check(nlog - b == 2 && !flag_eos, "R5 first burst", nlog - b, 2);
    check(!run, "R6 run clears after burst", run, 0);
    wr(A_CTRL, 32'h1); wait_idle();
    check(nlog - b == 4 && !flag_eos, "R5 second burst", nlog - b, 4);
    wr(A_CTRL, 32'h1); wait_idle();
    check(nlog - b == 5 && flag_eos, "R5 short final burst", nlog - b, 5);
    check_order(b, 5, 0, 16, "R5 order");
    wr(A_CLR, 32'hF);
  endtask

  task automatic t_hw_single();
    int b = nlog;
    wr(A_MODE, mk_mode(1, 0, 0, 0, 1, 1));
    wr(A_CTRL, 32'h1);
    wr(5'd0, 32'd31);
    wr(A_MODE, mk_mode(0, 0, 0, 0, 1, 0));
    repeat (20) tick();
    check(nlog == b && run, "R3 hw waits for edge", nlog - b, 0);
    tick(); trig = 1'b1; tick(); trig = 1'b0;
    wait_convs(b + 2);
    check(nlog - b == 2 && run && flag_eos, "R3 hw pass keeps run", nlog - b, 2);
    check(chlog[b] == rchan(0), "R12 rank frozen", chlog[b], rchan(0));
    tick(); trig = 1'b1; tick(); trig = 1'b0;
    wait_convs(b + 4);
    check(nlog - b == 4, "R12 length frozen", nlog - b, 4);
    wr(A_CTRL, 32'h2);
    tick();
    check(!run && !stopping, "R10 stop ends run", run, 0);
    wr(A_CLR, 32'hF);
  endtask

  task automatic t_cont_stop();
    int b = nlog;
    int n;
    wr(A_MODE, mk_mode(2, 0, 1, 0, 1, 0));
    wr(A_CTRL, 32'h1);
    for (int i = 0; i < 400 && nlog < b + 7; i++) tick();
    stall = 1;
    check(run && flag_eos, "R4 still running", run, 1);
    check_order(b, 7, 0, 3, "R4 wrap order");
    wr(A_CLR, 32'hF);
    tick(); cfg_we = 1'b1; cfg_addr = A_CTRL; cfg_wdata = 32'h2;
    tick(); cfg_we = 1'b0;
    check(stopping && conv_abort && run, "R10 stop pending", stopping, 1);
    tick();
    check(!run && !stopping && !conv_abort, "R10 stop done", run, 0);
    n = nlog;
    stall = 0;
    repeat (20) tick();
    check(nlog == n && !flag_eoc, "R10 discarded", nlog - n, 0);
    wr(A_MODE, mk_mode(0, 0, 0, 0, 1, 0));
    wr(A_CTRL, 32'h1); wait_idle();
    check(chlog[nlog - 1] == rchan(0), "R10 pointer back to rank 0",
          chlog[nlog - 1], rchan(0));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) tick();
    t_reset();
    rst_n = 1'b1;
    tick();
    for (int i = 0; i < 16; i++) wr(5'(i), 32'(rchan(i)));
    t_single_sw();
    t_keep_and_read();
    t_forbidden();
    t_disc_sw();
    t_hw_single();
    t_cont_stop();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule